// File: doc/BRIEF.md
# Interrupt Vector Responder

This block is the slave side of an interrupting peripheral on a 32-bit asynchronous-style bus. An internal event makes the request pending. While it is pending, the block pulls one active-low request line low, at the priority level chosen by static configuration. The bus master answers with an interrupt acknowledge read. The block recognises that read in one of two ways. It can decode the encoded function code and address, or it can watch the dedicated acknowledge strobe for its own level.

On recognising the cycle, the block answers in one of two ways. It can put its programmed 8-bit vector on the byte lane that serves as the low byte of the configured port width and signal a size acknowledge. Or it can request autovectoring. It holds the handshake until the master drops its strobes, and it clears the pending request at the moment it grants. Every output is registered, so the answer appears one clock after the strobes and decode are seen.

Top module: `ivr_responder`

## Requirements
- R1: Out of reset, every request line is high, both size-acknowledge lines and the autovector line are high (negated), the data enable is low and the data word is zero.
- R2: A one-cycle pulse on `irq_event_i` makes the request pending. While it is pending, `irq_no[L-1]` is low, where L is `cfg_level_i`, and all other request lines stay high. The line stays low through any cycles that do not acknowledge it. A configured level of 0 never raises a request.
- R3: With `cfg_strobe_mode_i` low, an acknowledge cycle needs several conditions at once. `fc_i` is 4'b0111, `addr_i[19:16]` is 4'hF, `addr_i[3:1]` equals the configured level and every other address bit is one. Both `as_ni` and `ds_ni` are low and a request is pending. The block then answers on the following clock edge.
- R4: With `cfg_strobe_mode_i` high, the acknowledge condition is different. It is `iack_ni[L-1]` low together with both strobes low and a pending request. The function code and address are then ignored.
- R5: A cycle that fails the decode does not produce any acknowledge and does not enable the data bus. A wrong level or a wrong function code fails it, and so does a cycle with no request pending.
- R6: The vector goes on bits 31:24 for port code 0 (8-bit), on bits 23:16 for port code 1 (16-bit), and on bits 7:0 for port codes 2 and 3 (32-bit). All other data bits are zero.
- R7: `dsack_no[1]` and `dsack_no[0]` are active low. A vectored answer drives 2'b10 for port code 0, 2'b01 for port code 1 and 2'b00 for port codes 2 and 3. The data enable is high while the size acknowledge is given.
- R8: With `cfg_autovec_i` high, the answer pulls `avec_no` low, leaves `dsack_no` at 2'b11 and keeps the data enable low.
- R9: While an answer is held, negating either `as_ni` or `ds_ni` negates every acknowledge line and the data enable on the next clock edge.
- R10: The pending request clears on the edge where the answer starts, so the request line goes high together with the acknowledge. It becomes pending again only on a new event. An event sampled on that same edge keeps it pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| irq_event_i | input | 1 | Internal event pulse that makes the request pending |
| cfg_level_i | input | 3 | Static request level, 1 to 7 (0 disables) |
| cfg_vector_i | input | 8 | Static vector number |
| cfg_port_i | input | 2 | Port width code: 0 = 8-bit, 1 = 16-bit, 2/3 = 32-bit |
| cfg_autovec_i | input | 1 | Answer with autovector instead of a vector |
| cfg_strobe_mode_i | input | 1 | Decode from the per-level acknowledge strobe |
| addr_i | input | 32 | Bus address |
| fc_i | input | 4 | Function code |
| as_ni | input | 1 | Address strobe, active low |
| ds_ni | input | 1 | Data strobe, active low |
| iack_ni | input | 7 | Per-level acknowledge strobes, bit L-1 for level L, active low |
| irq_no | output | 7 | Request lines, bit L-1 for level L, active low |
| data_o | output | 32 | Data word carrying the vector |
| data_oe_o | output | 1 | Data bus drive enable |
| dsack_no | output | 2 | Size acknowledge pair, active low |
| avec_no | output | 1 | Autovector request, active low |

## Verification
The bench places the vector under each port width. A design with a wrong lane shows the byte in the wrong position, and one with a wrong size encoding shows the wrong pair on `dsack_no`. Near-miss cycles test the decode: a wrong level, a wrong function code, and a correct encoded address with the strobe missing in strobe mode. A decode that is too loose answers one of these. The bench also tries a second acknowledge after a grant, and a loose design answers it from a stale request. It raises an event on the very edge of a grant, and a design that lets the clear win drops a request it still owes. A design that releases late keeps the acknowledge or the data enable one cycle after the data strobe is dropped, while the address strobe is still held.

// File: rtl/ivr_pkg.sv
package ivr_pkg;

    // Function code for the processor address space
    localparam logic [3:0] FC_CPU_SPACE = 4'b0111;
    // Address type field value meaning interrupt acknowledge
    localparam logic [3:0] TYPE_IACK    = 4'hF;
    localparam int         TYPE_LSB     = 16;
    localparam int         LEVEL_LSB    = 1;

    typedef enum logic [1:0] {
        PORT_8   = 2'd0,
        PORT_16  = 2'd1,
        PORT_32  = 2'd2,
        PORT_32B = 2'd3
    } port_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_HOLD = 1'b1
    } hs_state_e;

    // Active-low size acknowledge pair for a given port width
    function automatic logic [1:0] size_ack_n(input port_e p);
        case (p)
            PORT_8:  size_ack_n = 2'b10;
            PORT_16: size_ack_n = 2'b01;
            default: size_ack_n = 2'b00;
        endcase
    endfunction

endpackage

// File: rtl/ivr_decode.sv
module ivr_decode #(
    parameter int ADDR_W = 32,
    parameter int LEVELS = 7,
    parameter int LVL_W  = 3
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [3:0]        fc_i,
    input  logic [LEVELS-1:0] iack_ni,
    input  logic [LVL_W-1:0]  level_i,
    input  logic              strobe_mode_i,
    output logic              match_o
);
    import ivr_pkg::*;

    logic [ADDR_W-1:0] want_addr;
    logic              enc_hit;
    logic              line_hit;

    // Expected address: all ones except the level field
    always_comb begin
        want_addr = '1;
        want_addr[TYPE_LSB +: 4]      = TYPE_IACK;
        want_addr[LEVEL_LSB +: LVL_W] = level_i;
    end

    assign enc_hit = (fc_i == FC_CPU_SPACE) && (addr_i == want_addr);

    // Select the acknowledge strobe belonging to the configured level
    always_comb begin
        line_hit = 1'b0;
        for (int i = 0; i < LEVELS; i++) begin
            if (level_i == LVL_W'(i + 1)) begin
                line_hit = ~iack_ni[i];
            end
        end
    end

    assign match_o = (level_i != '0) && (strobe_mode_i ? line_hit : enc_hit);

endmodule

// File: rtl/ivr_lane.sv
module ivr_lane #(
    parameter int DATA_W = 32,
    parameter int VEC_W  = 8
) (
    input  logic [1:0]        port_i,
    input  logic [VEC_W-1:0]  vector_i,
    output logic [DATA_W-1:0] word_o
);
    import ivr_pkg::*;

    localparam int LANE_8  = DATA_W - VEC_W;
    localparam int LANE_16 = DATA_W - 2 * VEC_W;
    localparam int LANE_32 = 0;

    always_comb begin
        word_o = '0;
        case (port_e'(port_i))
            PORT_8:  word_o[LANE_8  +: VEC_W] = vector_i;
            PORT_16: word_o[LANE_16 +: VEC_W] = vector_i;
            default: word_o[LANE_32 +: VEC_W] = vector_i;
        endcase
    end

endmodule

// File: rtl/ivr_responder.sv
module ivr_responder #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int VEC_W  = 8,
    parameter int LEVELS = 7,
    parameter int LVL_W  = $clog2(LEVELS + 1)
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              irq_event_i,
    input  logic [LVL_W-1:0]  cfg_level_i,
    input  logic [VEC_W-1:0]  cfg_vector_i,
    input  logic [1:0]        cfg_port_i,
    input  logic              cfg_autovec_i,
    input  logic              cfg_strobe_mode_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [3:0]        fc_i,
    input  logic              as_ni,
    input  logic              ds_ni,
    input  logic [LEVELS-1:0] iack_ni,
    output logic [LEVELS-1:0] irq_no,
    output logic [DATA_W-1:0] data_o,
    output logic              data_oe_o,
    output logic [1:0]        dsack_no,
    output logic              avec_no
);
    import ivr_pkg::*;

    typedef struct packed {
        hs_state_e         st;
        logic              pend;
        logic [1:0]        dsack_n;
        logic              avec_n;
        logic              oe;
        logic [DATA_W-1:0] data;
    } regs_t;

    localparam regs_t RESET_VAL = '{
        st:      ST_IDLE,
        pend:    1'b0,
        dsack_n: 2'b11,
        avec_n:  1'b1,
        oe:      1'b0,
        data:    '0
    };

    regs_t             r_d, r_q;
    logic              match;
    logic [DATA_W-1:0] lane_word;
    logic              strobes_on;

    ivr_decode #(
        .ADDR_W (ADDR_W),
        .LEVELS (LEVELS),
        .LVL_W  (LVL_W)
    ) u_decode (
        .addr_i        (addr_i),
        .fc_i          (fc_i),
        .iack_ni       (iack_ni),
        .level_i       (cfg_level_i),
        .strobe_mode_i (cfg_strobe_mode_i),
        .match_o       (match)
    );

    ivr_lane #(
        .DATA_W (DATA_W),
        .VEC_W  (VEC_W)
    ) u_lane (
        .port_i   (cfg_port_i),
        .vector_i (cfg_vector_i),
        .word_o   (lane_word)
    );

    assign strobes_on = ~as_ni & ~ds_ni;

    always_comb begin
        r_d = r_q;
        case (r_q.st)
            ST_IDLE: begin
                if (r_q.pend && strobes_on && match) begin
                    r_d.st   = ST_HOLD;
                    r_d.pend = 1'b0;
                    if (cfg_autovec_i) begin
                        r_d.avec_n = 1'b0;
                        r_d.oe     = 1'b0;
                        r_d.data   = '0;
                    end else begin
                        r_d.dsack_n = size_ack_n(port_e'(cfg_port_i));
                        r_d.oe      = 1'b1;
                        r_d.data    = lane_word;
                    end
                end
            end
            default: begin
                if (!strobes_on) begin
                    r_d.st      = ST_IDLE;
                    r_d.dsack_n = 2'b11;
                    r_d.avec_n  = 1'b1;
                    r_d.oe      = 1'b0;
                    r_d.data    = '0;
                end
            end
        endcase
        // A fresh event wins over the clear of a grant on the same edge
        if (irq_event_i && (cfg_level_i != '0)) begin
            r_d.pend = 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            r_q <= RESET_VAL;
        end else begin
            r_q <= r_d;
        end
    end

    generate
        for (genvar g = 0; g < LEVELS; g++) begin : g_req
            assign irq_no[g] = ~(r_q.pend && (cfg_level_i == LVL_W'(g + 1)));
        end
    endgenerate

    assign data_o    = r_q.data;
    assign data_oe_o = r_q.oe;
    assign dsack_no  = r_q.dsack_n;
    assign avec_no   = r_q.avec_n;

endmodule

// File: rtl/ivr_checker.sv
module ivr_checker #(
    parameter int LEVELS = 7
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              irq_event_i,
    input logic              as_ni,
    input logic              ds_ni,
    input logic [1:0]        cfg_port_i,
    input logic [LEVELS-1:0] irq_no,
    input logic              data_oe_o,
    input logic [1:0]        dsack_no,
    input logic              avec_no
);
    logic       ack;
    logic [1:0] exp_pair;

    assign ack = (dsack_no != 2'b11) || !avec_no;
    assign exp_pair = (cfg_port_i == 2'd0) ? 2'b10 :
                      (cfg_port_i == 2'd1) ? 2'b01 : 2'b00;

    // R7: size acknowledge pattern follows the port width, with the data enable on
    a_r7_size_pair: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (dsack_no != 2'b11) |-> (dsack_no == exp_pair) && data_oe_o);

    // R8: autovector excludes size acknowledge and data drive
    a_r8_autovec_alone: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !avec_no |-> (dsack_no == 2'b11) && !data_oe_o);

    // R9: strobe negation releases on the next edge
    a_r9_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ack && (as_ni || ds_ni)) |=> (!ack && !data_oe_o));

    // R9: data drive only inside an answer
    a_r9_oe_in_answer: assert property (@(posedge clk_i) disable iff (!rst_ni)
        data_oe_o |-> ack);

    // R10: grant clears the request unless an event arrived on that edge
    a_r10_clear_on_grant: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(ack) |-> ((&irq_no) || $past(irq_event_i)));

    // R2: a request is only withdrawn by a grant
    a_r2_hold_until_grant: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(&irq_no) |-> $rose(ack));

endmodule

bind ivr_responder ivr_checker #(.LEVELS(LEVELS)) u_ivr_checker (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .irq_event_i (irq_event_i),
    .as_ni       (as_ni),
    .ds_ni       (ds_ni),
    .cfg_port_i  (cfg_port_i),
    .irq_no      (irq_no),
    .data_oe_o   (data_oe_o),
    .dsack_no    (dsack_no),
    .avec_no     (avec_no)
);

// File: tb/tb_ivr_responder.sv
`timescale 1ns/1ps
module tb_ivr_responder;

    typedef struct packed {
        logic [1:0]  dsack_n;
        logic        avec_n;
        logic        oe;
        logic [31:0] data;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ev = 1'b0;
    logic [2:0]  cfg_level = 3'd5;
    logic [7:0]  cfg_vec = 8'hA5;
    logic [1:0]  cfg_port = 2'd2;
    logic        cfg_av = 1'b0;
    logic        cfg_sm = 1'b0;
    logic [31:0] addr = '1;
    logic [3:0]  fc = 4'd0;
    logic        as_n = 1'b1;
    logic        ds_n = 1'b1;
    logic [6:0]  iack_n = '1;
    logic [6:0]  irq_n;
    logic [31:0] data;
    logic        oe;
    logic [1:0]  dsack_n;
    logic        avec_n;

    int   checks = 0;
    int   errors = 0;
    bit   done = 1'b0;
    exp_t q_exp[$];

    always #2 clk = ~clk;

    ivr_responder dut (
        .clk_i             (clk),
        .rst_ni            (rst_n),
        .irq_event_i       (ev),
        .cfg_level_i       (cfg_level),
        .cfg_vector_i      (cfg_vec),
        .cfg_port_i        (cfg_port),
        .cfg_autovec_i     (cfg_av),
        .cfg_strobe_mode_i (cfg_sm),
        .addr_i            (addr),
        .fc_i              (fc),
        .as_ni             (as_n),
        .ds_ni             (ds_n),
        .iack_ni           (iack_n),
        .irq_no            (irq_n),
        .data_o            (data),
        .data_oe_o         (oe),
        .dsack_no          (dsack_n),
        .avec_no           (avec_n)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic chk_irq(input logic [2:0] lvl, input string req);
        logic [6:0] e;
        e = '1;
        if (lvl != 0) e[lvl-1] = 1'b0;
        chk(irq_n == e, req, 64'(irq_n), 64'(e));
    endtask

    task automatic pulse_event();
        @(negedge clk);
        ev = 1'b1;
        @(negedge clk);
        ev = 1'b0;
    endtask

    // Driver: one bus cycle; expected answers go to the scoreboard queue
    task automatic bus_cycle(input logic [2:0] lvl_bus, input logic [3:0] fcode,
                             input bit use_line, input bit fire_ev,
                             input bit expect_ack, input exp_t e, input string req);
        @(negedge clk);
        if (expect_ack) q_exp.push_back(e);
        addr = '1;
        addr[3:1] = lvl_bus;
        fc = fcode;
        iack_n = '1;
        if (use_line && lvl_bus != 0) iack_n[lvl_bus-1] = 1'b0;
        as_n = 1'b0;
        ds_n = 1'b0;
        if (fire_ev) ev = 1'b1;
        @(negedge clk);
        ev = 1'b0;
        repeat (2) @(negedge clk);
        if (expect_ack) begin
            chk(oe == e.oe, req, 64'(oe), 64'(e.oe));
        end else begin
            chk(dsack_n == 2'b11 && avec_n && !oe, req,
                64'({dsack_n, avec_n, oe}), 64'(4'b1110));
        end
        ds_n = 1'b1;
        @(negedge clk);
        // R9: released one edge after the data strobe drops, address strobe still low
        chk(dsack_n == 2'b11 && avec_n && !oe, "R9",
            64'({dsack_n, avec_n, oe}), 64'(4'b1110));
        as_n = 1'b1;
        iack_n = '1;
        fc = 4'd0;
        @(negedge clk);
    endtask

    // Monitor: compare each new answer against the scoreboard
    initial begin
        bit prev_act = 1'b0;
        forever begin
            @(negedge clk);
            if (rst_n) begin
                bit act;
                act = (dsack_n != 2'b11) || !avec_n;
                if (act && !prev_act) begin
                    if (q_exp.size() == 0) begin
                        chk(1'b0, "R5 unexpected answer", 64'({dsack_n, avec_n}), 64'(3'b111));
                    end else begin
                        exp_t e;
                        e = q_exp.pop_front();
                        chk(dsack_n == e.dsack_n, "R7 size pair", 64'(dsack_n), 64'(e.dsack_n));
                        chk(avec_n == e.avec_n, "R8 autovector", 64'(avec_n), 64'(e.avec_n));
                        chk(oe == e.oe, "R7 data enable", 64'(oe), 64'(e.oe));
                        if (e.oe) chk(data == e.data, "R6 lane", 64'(data), 64'(e.data));
                    end
                end
                prev_act = act;
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        exp_t none;
        none = '0;
        repeat (4) @(negedge clk);
        // R1 reset state
        chk(irq_n == 7'h7F && dsack_n == 2'b11 && avec_n && !oe && data == 0, "R1",
            64'({irq_n, dsack_n, avec_n, oe}), 64'({7'h7F, 2'b11, 1'b1, 1'b0}));
        rst_n = 1'b1;
        @(negedge clk);
        chk_irq(0, "R1");

        // Level 5, 32-bit port, encoded decode
        pulse_event();
        chk_irq(5, "R2 request");
        bus_cycle(3'd3, 4'b0111, 0, 0, 0, none, "R5 wrong level");
        chk_irq(5, "R2 hold");
        bus_cycle(3'd5, 4'b0110, 0, 0, 0, none, "R5 wrong fc");
        bus_cycle(3'd5, 4'b0111, 0, 0, 1, '{2'b00, 1'b1, 1'b1, 32'h0000_00A5}, "R3 encoded");
        chk_irq(0, "R10 cleared");
        bus_cycle(3'd5, 4'b0111, 0, 0, 0, none, "R5 not pending");

        // 16-bit port
        cfg_vec = 8'h3C; cfg_port = 2'd1;
        pulse_event();
        bus_cycle(3'd5, 4'b0111, 0, 0, 1, '{2'b01, 1'b1, 1'b1, 32'h003C_0000}, "R6 16-bit");

        // 8-bit port at level 1
        cfg_level = 3'd1; cfg_vec = 8'h81; cfg_port = 2'd0;
        pulse_event();
        chk_irq(1, "R2 level 1");
        bus_cycle(3'd1, 4'b0111, 0, 0, 1, '{2'b10, 1'b1, 1'b1, 32'h8100_0000}, "R6 8-bit");

        // Autovector at level 2
        cfg_level = 3'd2; cfg_av = 1'b1; cfg_port = 2'd2;
        pulse_event();
        bus_cycle(3'd2, 4'b0111, 0, 0, 1, '{2'b11, 1'b0, 1'b0, 32'h0}, "R8 autovector");
        chk_irq(0, "R10 autovector clears");
        cfg_av = 1'b0;

        // Strobe decode at level 7
        cfg_level = 3'd7; cfg_sm = 1'b1; cfg_vec = 8'h5A; cfg_port = 2'd3;
        pulse_event();
        bus_cycle(3'd7, 4'b0111, 0, 0, 0, none, "R4 encoded ignored");
        chk_irq(7, "R4 still pending");
        bus_cycle(3'd7, 4'b0000, 1, 0, 1, '{2'b00, 1'b1, 1'b1, 32'h0000_005A}, "R4 strobe");
        cfg_sm = 1'b0;

        // Event on the grant edge keeps the request
        cfg_level = 3'd3; cfg_vec = 8'hC3; cfg_port = 2'd2;
        pulse_event();
        bus_cycle(3'd3, 4'b0111, 0, 1, 1, '{2'b00, 1'b1, 1'b1, 32'h0000_00C3}, "R10 event at grant");
        chk_irq(3, "R10 repended");
        bus_cycle(3'd3, 4'b0111, 0, 0, 1, '{2'b00, 1'b1, 1'b1, 32'h0000_00C3}, "R10 second grant");
        chk_irq(0, "R10 cleared again");

        // Level 0 disables the request
        cfg_level = 3'd0;
        pulse_event();
        chk_irq(0, "R2 level zero");
        bus_cycle(3'd0, 4'b0111, 0, 0, 0, none, "R5 level zero");

        repeat (3) @(negedge clk);
        chk(q_exp.size() == 0, "R3 all answers seen", 64'(q_exp.size()), 64'(0));
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule